// File: doc/BRIEF.md
# 64-bit Interval Timer with Register Bus

This peripheral counts prescaled ticks in a 64-bit counter and raises a flag each time the count matches a programmed 64-bit period. Software reaches it through a simple 32-bit register bus with address, write strobe, read strobe, write data and read data. The same bus controls an interrupt output. The timer runs either continuously, wrapping to zero on every match, or once, stopping at the first match.

Two enable strobes feed the timer. One belongs to the bus clock domain. The other comes from a slower alternate source and is brought into the bus domain by a two-flop synchroniser with rising-edge detection. A mode bit chooses between the two strobes, and a 4-bit prescaler then divides the chosen strobe. The period is loaded as two 32-bit halves, high half first. The running count is read as two halves. Reading the low half captures the high half in the same cycle, so a later read of the high half always matches it.

Top module: `ivt64_timer`

## Requirements
- R1: After reset, every readable register reads zero, the count is zero, the timer is stopped and `irq` is low.
- R2: A write to offset 0x0C only fills a holding register. The next write to offset 0x08 commits {held high half, written low half} as the 64-bit period. Reads at 0x08 and 0x0C return the committed period.
- R3: A write to offset 0x00 with bit 0 set starts the timer. With bit 8 set, the write stops the timer and clears the count and the prescaler phase. If one write sets both bits, bit 8 wins.
- R4: On each prescaled step the running count increases by one. If the count already equals the period on that step, the status bit is set instead. In continuous mode (bit 0 of the mode register at 0x04 set) the count then returns to zero and keeps counting, so one cycle takes period+1 steps.
- R5: In one-shot mode (mode bit 0 clear), the step that matches the period sets the status bit and stops the timer. The count stays at the period value.
- R6: Mode bits 11:8 hold a prescaler value p. The counter advances once per p+1 selected ticks.
- R7: With mode bit 3 set, each rising edge of `tick_alt` gives one tick after synchronisation, and `tick_main` is ignored. With mode bit 3 clear, each cycle with `tick_main` high gives one tick. `tick_alt` must stay at each level for at least three bus clock cycles.
- R8: A read at offset 0x1C returns the status in bit 0 and clears it. If the status is set in the same cycle as such a read, the status ends up set.
- R9: `irq` is high while the status bit and bit 0 of the interrupt enable register at 0x10 are both set.
- R10: A read at 0x20 returns count bits 31:0 and captures count bits 63:32. A read at 0x24 returns the captured value.
- R11: The mode register reads back only bits 0, 3 and 11:8. Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tick_main | input | 1 | Tick enable in the bus clock domain |
| tick_alt | input | 1 | Slow alternate tick strobe, asynchronous |
| irq | output | 1 | Period-reached interrupt |

## Verification
Two events can land in the same clock cycle: the counter matching the period, which sets the status bit, and a status read, which clears it. The bench provokes this with a period of zero and no prescaling, so every tick is a match. It drives a tick and a status read in the same cycle. It then expects the status bit to still be set on the following read, and to read zero on the read after that. A second collision, a start and a soft reset in one control write, is judged by checking that the count no longer advances on later ticks.

// File: rtl/ivt64_pkg.sv
package ivt64_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int PRE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PER_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PER_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h24;

  localparam int BIT_START = 0;
  localparam int BIT_SRST  = 8;
  localparam int BIT_CONT  = 0;
  localparam int BIT_ALT   = 3;
  localparam int BIT_PRE   = 8;
endpackage

// File: rtl/ivt64_edge_sync.sv
module ivt64_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // A rising edge produces a single-cycle pulse
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ivt64_tick_gen.sv
module ivt64_tick_gen #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_main,
  input  logic             alt_rise,
  input  logic             sel_alt,
  input  logic [PRE_W-1:0] pres,
  input  logic             clr,
  output logic             step
);
  logic [PRE_W-1:0] phase_q, phase_d;
  logic             tick;

  always_comb begin
    tick    = sel_alt ? alt_rise : tick_main;
    step    = tick && (phase_q >= pres) && !clr;
    phase_d = phase_q;
    if (clr)       phase_d = '0;
    else if (step) phase_d = '0;
    else if (tick) phase_d = phase_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // With a prescaler value above zero, steps are never back to back
  assert_no_adjacent_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pres != '0) ##1 ($stable(pres) && !clr) |-> !step);
endmodule

// File: rtl/ivt64_counter.sv
module ivt64_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             start,
  input  logic             clr,
  input  logic             cont,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;

  always_comb begin
    hit   = step && running && (count == period) && !clr;
    cnt_d = count;
    run_d = running;
    if (clr) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else begin
      if (step && running) begin
        if (count == period) begin
          if (cont) cnt_d = '0;
          else      run_d = 1'b0;
        end else begin
          cnt_d = count + CNT_W'(1);
        end
      end
      if (start) run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      count   <= cnt_d;
      running <= run_d;
    end
  end

  assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !running);
  assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && running && count != period && !clr) |=> count == $past(count) + CNT_W'(1));
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cont && !start) |=> !running);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr) |=> $stable(count));
endmodule

// File: rtl/ivt64_timer.sv
module ivt64_timer
  import ivt64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tick_main,
  input  logic              tick_alt,
  output logic              irq
);
  logic             mode_cont_q, mode_alt_q, ien_q, stat_q;
  logic [PRE_W-1:0] mode_pre_q;
  logic [BUS_W-1:0] per_hold_q, snap_q;
  logic [CNT_W-1:0] period_q;

  logic             mode_cont_d, mode_alt_d, ien_d, stat_d;
  logic [PRE_W-1:0] mode_pre_d;
  logic [BUS_W-1:0] per_hold_d, snap_d;
  logic [CNT_W-1:0] period_d;

  logic             wr_ctrl, start, clr, rd_stat, rd_cnt_lo;
  logic             alt_rise, step, hit, running;
  logic [CNT_W-1:0] count;

  assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
  assign clr       = wr_ctrl && bus_wdata[BIT_SRST];
  assign start     = wr_ctrl && bus_wdata[BIT_START];
  assign rd_stat   = bus_re && (bus_addr == OFS_STAT);
  assign rd_cnt_lo = bus_re && (bus_addr == OFS_CNT_LO);

  ivt64_edge_sync #(.STAGES(2)) u_alt_sync (
    .clk(clk), .rst_n(rst_n), .din(tick_alt), .rise(alt_rise)
  );

  ivt64_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_main(tick_main), .alt_rise(alt_rise),
    .sel_alt(mode_alt_q), .pres(mode_pre_q), .clr(clr), .step(step)
  );

  ivt64_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .start(start), .clr(clr),
    .cont(mode_cont_q), .period(period_q), .count(count),
    .running(running), .hit(hit)
  );

  always_comb begin
    mode_cont_d = mode_cont_q;
    mode_alt_d  = mode_alt_q;
    mode_pre_d  = mode_pre_q;
    per_hold_d  = per_hold_q;
    period_d    = period_q;
    ien_d       = ien_q;
    snap_d      = snap_q;
    if (bus_we) begin
      unique case (bus_addr)
        OFS_MODE: begin
          mode_cont_d = bus_wdata[BIT_CONT];
          mode_alt_d  = bus_wdata[BIT_ALT];
          mode_pre_d  = bus_wdata[BIT_PRE +: PRE_W];
        end
        OFS_PER_HI: per_hold_d = bus_wdata;
        OFS_PER_LO: period_d   = {per_hold_q, bus_wdata};
        OFS_IEN:    ien_d      = bus_wdata[0];
        default: ;
      endcase
    end
    if (rd_cnt_lo) snap_d = count[CNT_W-1:BUS_W];
    // a match in the same cycle overrides the clear-on-read
    if (hit)          stat_d = 1'b1;
    else if (rd_stat) stat_d = 1'b0;
    else              stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cont_q <= 1'b0;
      mode_alt_q  <= 1'b0;
      mode_pre_q  <= '0;
      per_hold_q  <= '0;
      period_q    <= '0;
      ien_q       <= 1'b0;
      stat_q      <= 1'b0;
      snap_q      <= '0;
    end else begin
      mode_cont_q <= mode_cont_d;
      mode_alt_q  <= mode_alt_d;
      mode_pre_q  <= mode_pre_d;
      per_hold_q  <= per_hold_d;
      period_q    <= period_d;
      ien_q       <= ien_d;
      stat_q      <= stat_d;
      snap_q      <= snap_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = '0;
      OFS_MODE: begin
        bus_rdata[BIT_CONT]            = mode_cont_q;
        bus_rdata[BIT_ALT]             = mode_alt_q;
        bus_rdata[BIT_PRE +: PRE_W]    = mode_pre_q;
      end
      OFS_PER_LO: bus_rdata = period_q[BUS_W-1:0];
      OFS_PER_HI: bus_rdata = period_q[CNT_W-1:BUS_W];
      OFS_IEN:    bus_rdata[0] = ien_q;
      OFS_STAT:   bus_rdata[0] = stat_q;
      OFS_CNT_LO: bus_rdata = count[BUS_W-1:0];
      OFS_CNT_HI: bus_rdata = snap_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = stat_q & ien_q;

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !hit) |=> !stat_q);
  assert_stat_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_q);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien_q && !(bus_we && bus_addr == OFS_IEN)) |=> irq);
  assert_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_lo |=> snap_q == $past(count[CNT_W-1:BUS_W]));
endmodule

// File: tb/ivt64_timer_tb.sv
module ivt64_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_main = 1'b0, tick_alt = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ivt64_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_main(tick_main), .tick_alt(tick_alt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_main = 1'b1;
      @(negedge clk); tick_main = 1'b0;
    end
  endtask

  task automatic alt_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_alt = 1'b1;
      repeat (3) @(negedge clk);
      tick_alt = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic setup(input logic [31:0] per_hi, input logic [31:0] per_lo, input logic [31:0] mode);
    logic [31:0] d;
    wr(8'h00, 32'h100);
    wr(8'h0C, per_hi);
    wr(8'h08, per_lo);
    wr(8'h04, mode);
    rd(8'h1C, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h04, d); chk("R1 mode", d, 0);
    rd(8'h08, d); chk("R1 period lo", d, 0);
    rd(8'h1C, d); chk("R1 status", d, 0);
    rd(8'h20, d); chk("R1 count lo", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_period_load;
    logic [31:0] d;
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, d); chk("R2 high held only", d, 0);
    wr(8'h08, 32'h0000_0005);
    rd(8'h08, d); chk("R2 low committed", d, 5);
    rd(8'h0C, d); chk("R2 high committed", d, 1);
  endtask

  task automatic t_continuous;
    logic [31:0] d;
    setup(0, 3, 32'h1);
    wr(8'h00, 32'h1);
    tick(2);
    rd(8'h20, d); chk("R4 count after 2", d, 2);
    rd(8'h24, d); chk("R10 snapshot high", d, 0);
    tick(1);
    rd(8'h1C, d); chk("R4 no status before match", d, 0);
    tick(1);
    rd(8'h20, d); chk("R4 wrapped", d, 0);
    rd(8'h1C, d); chk("R8 status set", d, 1);
    rd(8'h1C, d); chk("R8 cleared by read", d, 0);
    tick(3);
    rd(8'h20, d); chk("R4 keeps counting", d, 3);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    setup(0, 1, 32'h1);
    wr(8'h10, 32'h1);
    wr(8'h00, 32'h1);
    tick(1);
    #1 chk("R9 irq low before match", {31'd0, irq}, 0);
    tick(1);
    #1 chk("R9 irq high", {31'd0, irq}, 1);
    wr(8'h10, 32'h0);
    #1 chk("R9 irq masked", {31'd0, irq}, 0);
    rd(8'h1C, d); chk("R9 status kept while masked", d, 1);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    setup(0, 2, 32'h0);
    wr(8'h00, 32'h1);
    tick(5);
    rd(8'h20, d); chk("R5 count holds period", d, 2);
    rd(8'h1C, d); chk("R5 status", d, 1);
    tick(2);
    rd(8'h1C, d); chk("R5 no new match when stopped", d, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    setup(0, 100, 32'h201);
    wr(8'h00, 32'h1);
    tick(9);
    rd(8'h20, d); chk("R6 divide by 3", d, 3);
    tick(2);
    rd(8'h20, d); chk("R6 partial phase", d, 3);
  endtask

  task automatic t_start_srst;
    logic [31:0] d;
    setup(0, 100, 32'h1);
    wr(8'h00, 32'h1);
    tick(3);
    wr(8'h00, 32'h101);
    tick(3);
    rd(8'h20, d); chk("R3 reset wins over start", d, 0);
    wr(8'h00, 32'h1);
    tick(2);
    rd(8'h20, d); chk("R3 start after reset", d, 2);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    setup(0, 0, 32'h1);
    wr(8'h00, 32'h1);
    @(negedge clk);
    tick_main = 1'b1; bus_addr = 8'h1C; bus_re = 1'b1;
    @(negedge clk);
    tick_main = 1'b0; bus_re = 1'b0;
    rd(8'h1C, d); chk("R8 set wins over read clear", d, 1);
    rd(8'h1C, d); chk("R8 cleared afterwards", d, 0);
  endtask

  task automatic t_alt;
    logic [31:0] d;
    setup(0, 100, 32'h9);
    wr(8'h00, 32'h1);
    alt_pulse(4);
    repeat (3) @(negedge clk);
    rd(8'h20, d); chk("R7 alt edges counted", d, 4);
    tick(3);
    rd(8'h20, d); chk("R7 main ignored in alt mode", d, 4);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R11 mode readback", d, 32'h0000_0F09);
    rd(8'h14, d); chk("R11 unmapped", d, 0);
    rd(8'h00, d); chk("R11 control reads zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period_load();
    t_continuous();
    t_irq();
    t_oneshot();
    t_prescale();
    t_start_srst();
    t_collision();
    t_alt();
    t_map();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule